// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Permission Check

This block is a small fully associative cache of page translations. A lookup presents a 32-bit virtual address, the identifier of the address space that is running, and the kind of access (load, store or instruction fetch). All eight entries compare their page number and identifier with the request in the same cycle. One cycle later the block reports a hit together with the physical address, or a miss, or a permission fault. The physical address is the cached physical page number followed by the unchanged 12 offset bits.

Each entry holds a 4-bit permission field. A miss raises only the miss flag, so a separate handler can walk the page tables and load the translation through the refill port. Because entries carry an address-space identifier, a context switch does not have to discard the cache. Two flush inputs are provided: one empties the whole cache, and one drops only the entries of a single address space.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits when an occupied entry holds both the requested virtual page number (bits 31:12) and the requested identifier. `rsp_valid` is high exactly in the cycle after `lk_valid`, and its result reflects the entries as they stood at the request edge.
- R2: On a hit with no fault, `rsp_pa` equals the stored 20-bit physical page number in bits 31:12, with the request's offset bits 11:0 in bits 11:0.
- R3: An entry whose page number matches but whose identifier differs from `lk_asid` does not hit. The lookup reports a miss.
- R4: The permission field is {V,R,W,X}, with V in bit 3 and X in bit 0. The access code `lk_acc` is 0 for load (needs R), 1 for store (needs W) and 2 for fetch (needs X). Code 3 is permitted by no entry. An access the entry does not permit gives `rsp_hit`=1 and `rsp_fault`=1.
- R5: A hit on an entry with V=0 faults for every access type, whatever R, W and X hold.
- R6: A fault forces `rsp_pa` to 0. A miss gives `rsp_miss`=1, `rsp_hit`=0, `rsp_fault`=0 and `rsp_pa`=0. `rsp_hit` and `rsp_miss` are never high together. When `rsp_valid` is low, all result outputs are 0.
- R7: A refill whose page number and identifier match no entry goes to the lowest-numbered unoccupied slot.
- R8: When no slot is free, a refill replaces the slot chosen by a round-robin pointer. The pointer resets to 0 and advances by one (modulo 8) after every accepted refill.
- R9: A refill whose page number and identifier match an existing entry overwrites that entry in place. No duplicate is created and no other entry is evicted.
- R10: `fl_all` empties every slot at the next edge. Lookups that follow then miss.
- R11: `fl_asid_en` empties only the slots whose identifier equals `fl_asid`. All other entries keep hitting.
- R12: A refill presented in the same cycle as either flush is dropped.
- R13: After reset every slot is empty and all response outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_va | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address-space identifier |
| lk_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| rf_en | input | 1 | Refill write strobe |
| rf_vpn | input | 20 | Virtual page number of the new mapping |
| rf_asid | input | 8 | Identifier of the new mapping |
| rf_ppn | input | 20 | Physical page number of the new mapping |
| rf_perm | input | 4 | Permission bits {V,R,W,X} |
| fl_all | input | 1 | Empty all entries |
| fl_asid_en | input | 1 | Empty entries of one identifier |
| fl_asid | input | 8 | Identifier to flush |
| rsp_valid | output | 1 | Result present (one cycle after request) |
| rsp_hit | output | 1 | Translation found |
| rsp_miss | output | 1 | No translation found |
| rsp_fault | output | 1 | Translation found but access refused |
| rsp_pa | output | 32 | Physical address (0 on miss or fault) |

## Verification
The assertions check the following on every cycle:
- the one-cycle request-to-response timing;
- that hit and miss exclude each other;
- that a fault always comes with a hit and a zero address;
- that the outputs are quiet when no response is due;
- that a lookup right after a full flush misses.

Which slot a refill takes (a free slot, the round-robin victim, or an in-place overwrite), how a selective flush spares the other identifiers, and the per-type permission outcomes depend on earlier history. Only the bench's scenarios can show these, by loading known mappings and then probing which ones still translate.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;
    localparam int VA_W    = 32;
    localparam int OFF_W   = 12;
    localparam int PPN_W   = 20;
    localparam int ASID_W  = 8;
    localparam int ENTRIES = 8;

    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam int IDX_W = $clog2(ENTRIES);

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // packed MSB-first: valid, read, write, execute
    typedef struct packed {
        logic v;
        logic r;
        logic w;
        logic x;
    } perm_t;

    typedef struct packed {
        logic              used;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        perm_t             perm;
    } entry_t;

    function automatic logic perm_allows(perm_t p, acc_e a);
        logic ok;
        case (a)
            ACC_LOAD:  ok = p.r;
            ACC_STORE: ok = p.w;
            ACC_FETCH: ok = p.x;
            default:   ok = 1'b0;
        endcase
        return ok & p.v;
    endfunction
endpackage

// File: rtl/tlb_tag_match.sv
`timescale 1ns/1ps
module tlb_tag_match
    import tlb_pkg::*;
(
    input  entry_t [ENTRIES-1:0] table_i,
    input  logic [VPN_W-1:0]     vpn_i,
    input  logic [ASID_W-1:0]    asid_i,
    output logic                 any_o,
    output logic [IDX_W-1:0]     idx_o
);
    logic [ENTRIES-1:0] match;

    // one comparator per slot, all in parallel
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = table_i[g].used
                        && (table_i[g].vpn  == vpn_i)
                        && (table_i[g].asid == asid_i);
    end

    always_comb begin
        any_o = |match;
        idx_o = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_victim_sel.sv
`timescale 1ns/1ps
module tlb_victim_sel
    import tlb_pkg::*;
(
    input  logic [ENTRIES-1:0] used_i,
    input  logic               dup_i,
    input  logic [IDX_W-1:0]   dup_idx_i,
    input  logic [IDX_W-1:0]   rr_i,
    output logic [IDX_W-1:0]   idx_o
);
    logic             have_free;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        have_free = ~&used_i;
        free_idx  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!used_i[i]) free_idx = IDX_W'(i);
        end
    end

    // priority: same tag in place, then lowest free slot, then round robin
    always_comb begin
        if (dup_i)          idx_o = dup_idx_i;
        else if (have_free) idx_o = free_idx;
        else                idx_o = rr_i;
    end
endmodule

// File: rtl/tlb_perm_check.sv
`timescale 1ns/1ps
module tlb_perm_check
    import tlb_pkg::*;
(
    input  perm_t perm_i,
    input  acc_e  acc_i,
    output logic  allow_o
);
    assign allow_o = perm_allows(perm_i, acc_i);
endmodule

// File: rtl/tlb_entry_store.sv
`timescale 1ns/1ps
module tlb_entry_store
    import tlb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush_all_i,
    input  logic                 flush_asid_en_i,
    input  logic [ASID_W-1:0]    flush_asid_i,
    input  logic                 wr_en_i,
    input  logic [IDX_W-1:0]     wr_idx_i,
    input  entry_t               wr_entry_i,
    output entry_t [ENTRIES-1:0] table_o,
    output logic [ENTRIES-1:0]   used_o,
    output logic [IDX_W-1:0]     rr_o
);
    entry_t [ENTRIES-1:0] slots;
    logic [IDX_W-1:0]     rr_q;
    logic                 wr_ok;

    assign wr_ok = wr_en_i && !flush_all_i && !flush_asid_en_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
            rr_q  <= '0;
        end else if (flush_all_i) begin
            for (int i = 0; i < ENTRIES; i++) slots[i].used <= 1'b0;
        end else if (flush_asid_en_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (slots[i].asid == flush_asid_i) slots[i].used <= 1'b0;
            end
        end else if (wr_ok) begin
            slots[wr_idx_i] <= wr_entry_i;
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_used
        assign used_o[g] = slots[g].used;
    end

    assign table_o = slots;
    assign rr_o    = rr_q;
endmodule

// File: rtl/asid_tlb.sv
`timescale 1ns/1ps
module asid_tlb
    import tlb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_acc,
    input  logic              rf_en,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [ASID_W-1:0] rf_asid,
    input  logic [PPN_W-1:0]  rf_ppn,
    input  logic [3:0]        rf_perm,
    input  logic              fl_all,
    input  logic              fl_asid_en,
    input  logic [ASID_W-1:0] fl_asid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_pa
);
    entry_t [ENTRIES-1:0] tbl;
    logic [ENTRIES-1:0]   used;
    logic [IDX_W-1:0]     rr_ptr;

    logic             lk_any, rf_dup, allow;
    logic [IDX_W-1:0] lk_idx, rf_dup_idx, wr_idx;
    entry_t           lk_ent, rf_ent;

    assign rf_ent = '{used: 1'b1, asid: rf_asid, vpn: rf_vpn,
                      ppn: rf_ppn, perm: perm_t'(rf_perm)};

    tlb_tag_match u_lookup_cmp (
        .table_i (tbl),
        .vpn_i   (lk_va[VA_W-1:OFF_W]),
        .asid_i  (lk_asid),
        .any_o   (lk_any),
        .idx_o   (lk_idx)
    );

    tlb_tag_match u_refill_cmp (
        .table_i (tbl),
        .vpn_i   (rf_vpn),
        .asid_i  (rf_asid),
        .any_o   (rf_dup),
        .idx_o   (rf_dup_idx)
    );

    tlb_victim_sel u_victim (
        .used_i    (used),
        .dup_i     (rf_dup),
        .dup_idx_i (rf_dup_idx),
        .rr_i      (rr_ptr),
        .idx_o     (wr_idx)
    );

    tlb_entry_store u_store (
        .clk             (clk),
        .rst             (rst),
        .flush_all_i     (fl_all),
        .flush_asid_en_i (fl_asid_en),
        .flush_asid_i    (fl_asid),
        .wr_en_i         (rf_en),
        .wr_idx_i        (wr_idx),
        .wr_entry_i      (rf_ent),
        .table_o         (tbl),
        .used_o          (used),
        .rr_o            (rr_ptr)
    );

    assign lk_ent = tbl[lk_idx];

    tlb_perm_check u_perm (
        .perm_i  (lk_ent.perm),
        .acc_i   (acc_e'(lk_acc)),
        .allow_o (allow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && lk_any;
            rsp_miss  <= lk_valid && !lk_any;
            rsp_fault <= lk_valid && lk_any && !allow;
            rsp_pa    <= (lk_valid && lk_any && allow)
                         ? {lk_ent.ppn, lk_va[OFF_W-1:0]} : '0;
        end
    end
endmodule

// File: rtl/tlb_checker.sv
`timescale 1ns/1ps
module tlb_checker
    import tlb_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            lk_valid,
    input logic            fl_all,
    input logic            rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_miss,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_pa
);
    assert_rsp_after_req_R1: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);

    assert_no_rsp_without_req_R1: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid);

    assert_hit_xor_miss_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_hit ^ rsp_miss));

    assert_fault_is_hit_zero_pa_R6: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_hit && rsp_pa == '0));

    assert_quiet_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_fault && rsp_pa == '0));

    assert_miss_after_flush_R10: assert property (@(posedge clk) disable iff (rst)
        fl_all ##1 lk_valid |=> rsp_miss);
endmodule

bind asid_tlb tlb_checker u_tlb_checker (
    .clk       (clk),
    .rst       (rst),
    .lk_valid  (lk_valid),
    .fl_all    (fl_all),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_pa    (rsp_pa)
);

// File: tb/tb_asid_tlb.sv
`timescale 1ns/1ps
module tb_asid_tlb;
    import tlb_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              lk_valid;
    logic [VA_W-1:0]   lk_va;
    logic [ASID_W-1:0] lk_asid;
    logic [1:0]        lk_acc;
    logic              rf_en;
    logic [VPN_W-1:0]  rf_vpn;
    logic [ASID_W-1:0] rf_asid;
    logic [PPN_W-1:0]  rf_ppn;
    logic [3:0]        rf_perm;
    logic              fl_all;
    logic              fl_asid_en;
    logic [ASID_W-1:0] fl_asid;
    logic              rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [PA_W-1:0]   rsp_pa;

    always #2.5 clk = ~clk;

    asid_tlb dut (.*);

    typedef struct packed {
        logic            hit;
        logic            fault;
        logic [PA_W-1:0] pa;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // monitor: pops one expected item for each response
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1", "response with nothing expected");
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_hit == e.hit && rsp_miss == !e.hit &&
                      rsp_fault == e.fault && rsp_pa == e.pa, t,
                      $sformatf("act hit=%0b miss=%0b fault=%0b pa=%h exp hit=%0b miss=%0b fault=%0b pa=%h",
                                rsp_hit, rsp_miss, rsp_fault, rsp_pa,
                                e.hit, !e.hit, e.fault, e.pa));
            end
        end
    end

    task automatic quiet();
        lk_valid = 0; rf_en = 0; fl_all = 0; fl_asid_en = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            quiet();
        end
    endtask

    task automatic refill(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                          input logic [PPN_W-1:0] ppn, input logic [3:0] perm);
        @(negedge clk);
        quiet();
        rf_en = 1; rf_vpn = vpn; rf_asid = asid; rf_ppn = ppn; rf_perm = perm;
    endtask

    task automatic flush_all_with_refill(input logic [VPN_W-1:0] vpn,
                                         input logic [ASID_W-1:0] asid);
        @(negedge clk);
        quiet();
        fl_all = 1;
        rf_en = 1; rf_vpn = vpn; rf_asid = asid; rf_ppn = 20'h0BEEF; rf_perm = 4'b1111;
    endtask

    task automatic flush_id(input logic [ASID_W-1:0] asid);
        @(negedge clk);
        quiet();
        fl_asid_en = 1; fl_asid = asid;
    endtask

    task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off,
                          input logic [ASID_W-1:0] asid, input logic [1:0] acc,
                          input logic ehit, input logic efault,
                          input logic [PPN_W-1:0] eppn, input string tag);
        exp_t e;
        @(negedge clk);
        quiet();
        lk_valid = 1; lk_va = {vpn, off}; lk_asid = asid; lk_acc = acc;
        e.hit   = ehit;
        e.fault = efault;
        e.pa    = (ehit && !efault) ? {eppn, off} : '0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: act=timeout exp=completion");
            finish_run();
        end
    end

    initial begin
        rst = 1;
        quiet();
        lk_va = '0; lk_asid = '0; lk_acc = '0;
        rf_vpn = '0; rf_asid = '0; rf_ppn = '0; rf_perm = '0; fl_asid = '0;
        repeat (4) @(negedge clk);
        check(!rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault && rsp_pa == '0, "R13",
              $sformatf("reset outputs act v=%0b h=%0b m=%0b f=%0b pa=%h exp all 0",
                        rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_pa));
        rst = 0;

        lookup(20'h00010, 12'h123, 8'd1, 2'd0, 0, 0, 0, "R13 empty after reset");

        // four mappings in identifier 1, four in identifier 2
        refill(20'h00010, 8'd1, 20'h00100, 4'b1100);
        refill(20'h00011, 8'd1, 20'h00101, 4'b1110);
        refill(20'h00012, 8'd1, 20'h00102, 4'b0000);
        refill(20'h00013, 8'd1, 20'h00103, 4'b1111);
        for (int i = 4; i < 8; i++) refill(20'h00010 + 20'(i), 8'd2, 20'h00100 + 20'(i), 4'b1111);

        lookup(20'h00010, 12'hABC, 8'd1, 2'd0, 1, 0, 20'h00100, "R1 R2 load hit");
        lookup(20'h00010, 12'h001, 8'd1, 2'd1, 1, 1, 0, "R4 store no W");
        lookup(20'h00010, 12'h002, 8'd1, 2'd2, 1, 1, 0, "R4 fetch no X");
        lookup(20'h00011, 12'hFFF, 8'd1, 2'd1, 1, 0, 20'h00101, "R4 store with W");
        lookup(20'h00011, 12'h004, 8'd1, 2'd2, 1, 1, 0, "R4 fetch no X on RW page");
        lookup(20'h00013, 12'h555, 8'd1, 2'd2, 1, 0, 20'h00103, "R4 fetch with X");
        lookup(20'h00013, 12'h555, 8'd1, 2'd3, 1, 1, 0, "R4 reserved code faults");
        lookup(20'h00012, 12'h010, 8'd1, 2'd0, 1, 1, 0, "R5 invalid page load");
        lookup(20'h00010, 12'h010, 8'd2, 2'd0, 0, 0, 0, "R3 wrong identifier");
        lookup(20'h00014, 12'h321, 8'd2, 2'd0, 1, 0, 20'h00104, "R1 second space hit");

        // overwrite in place (pointer 0 -> 1)
        refill(20'h00011, 8'd1, 20'h002AA, 4'b1111);
        lookup(20'h00011, 12'h0AA, 8'd1, 2'd2, 1, 0, 20'h002AA, "R9 overwritten mapping");
        lookup(20'h00010, 12'h0AA, 8'd1, 2'd0, 1, 0, 20'h00100, "R9 slot 0 kept");
        lookup(20'h00017, 12'h0AA, 8'd2, 2'd0, 1, 0, 20'h00107, "R9 slot 7 kept");

        flush_id(8'd2);
        lookup(20'h00014, 12'h000, 8'd2, 2'd0, 0, 0, 0, "R11 flushed space A");
        lookup(20'h00017, 12'h000, 8'd2, 2'd0, 0, 0, 0, "R11 flushed space B");
        lookup(20'h00010, 12'h777, 8'd1, 2'd0, 1, 0, 20'h00100, "R11 other space kept");

        // free slot 4 taken, not round-robin slot 1 (pointer 1 -> 2)
        refill(20'h00030, 8'd3, 20'h00300, 4'b1111);
        lookup(20'h00030, 12'h00C, 8'd3, 2'd0, 1, 0, 20'h00300, "R7 new entry");
        lookup(20'h00011, 12'h00C, 8'd1, 2'd0, 1, 0, 20'h002AA, "R7 slot 1 not evicted");
        lookup(20'h00013, 12'h00C, 8'd1, 2'd0, 1, 0, 20'h00103, "R7 slot 3 kept");

        // fill slots 5..7, pointer ends at 5
        for (int i = 5; i < 8; i++) refill(20'h00030 + 20'(i), 8'd3, 20'h00300 + 20'(i), 4'b1111);
        refill(20'h00040, 8'd4, 20'h00400, 4'b1111);
        lookup(20'h00035, 12'h100, 8'd3, 2'd0, 0, 0, 0, "R8 slot 5 evicted");
        lookup(20'h00036, 12'h100, 8'd3, 2'd0, 1, 0, 20'h00306, "R8 slot 6 kept");
        lookup(20'h00040, 12'h100, 8'd4, 2'd0, 1, 0, 20'h00400, "R8 new entry");
        refill(20'h00041, 8'd4, 20'h00401, 4'b1111);
        lookup(20'h00036, 12'h200, 8'd3, 2'd0, 0, 0, 0, "R8 slot 6 evicted next");
        lookup(20'h00037, 12'h200, 8'd3, 2'd0, 1, 0, 20'h00307, "R8 slot 7 kept");
        lookup(20'h00010, 12'h200, 8'd1, 2'd0, 1, 0, 20'h00100, "R8 slot 0 kept");

        flush_all_with_refill(20'h00050, 8'd5);
        lookup(20'h00050, 12'h000, 8'd5, 2'd0, 0, 0, 0, "R12 refill dropped");
        lookup(20'h00010, 12'h000, 8'd1, 2'd0, 0, 0, 0, "R10 all flushed");
        lookup(20'h00041, 12'h000, 8'd4, 2'd0, 0, 0, 0, "R10 all flushed 2");
        refill(20'h00050, 8'd5, 20'h00500, 4'b1111);
        lookup(20'h00050, 12'h9A9, 8'd5, 2'd2, 1, 0, 20'h00500, "R7 refill after flush");

        idle(4);
        check(exp_q.size() == 0, "R1",
              $sformatf("pending responses act=%0d exp=0", exp_q.size()));
        done = 1'b1;
        finish_run();
    end
endmodule